// File: doc/BRIEF.md
# Chip-Select Driven Conversion Sequencer with Serial Result Port

This controller sits between a decimating conversion engine and a three-wire host port. The port has an active-low select, a serial clock and a data line that can be driven or released. The select line alone decides what the converter does. Holding it low runs conversions back to back, and each result is shifted out as soon as it is ready. Holding it high parks the converter in power-down and releases the data line. Lowering it while a finished result is waiting starts the readout of that result.

Each result is 24 bits wide and is sent most significant bit first. The top eight bits therefore give the coarse input range before the fine bits follow. The data line changes on falling serial-clock edges, so the host samples on rising edges. The serial clock can come from the host. When the presence input reports that no host clock is driven, the controller makes its own serial clock by dividing the system clock. The controller then also drives that clock out for the 24 periods of the readout.

Top module: `serial_conv_ctrl`

## Requirements
- R1: While `chip_sel_n` is high, `ser_data_oe` and `ser_clk_oe` are low in that same cycle.
- R2: With `chip_sel_n` held low, the cycle that completes a readout also asserts `conv_start`, so conversions run back to back.
- R3: After reset the controller is idle with `pwr_down` high. `pwr_down` is high while idle or while holding a finished result, and low during a conversion and during a readout.
- R4: When `chip_sel_n` is low in the idle state, `conv_start` pulses for exactly one cycle and `pwr_down` is low from the next cycle.
- R5: If a conversion finishes while `chip_sel_n` is high, the result is kept and `pwr_down` goes high. The next low level on `chip_sel_n` starts its readout without starting a new conversion.
- R6: Bit 23 is shifted first and bit 0 last, so bits 23..16 (the coarse range) lead. Bit 23 is on `ser_data` when the readout begins. `ser_data` advances by one bit on each falling serial-clock edge and is otherwise constant.
- R7: A readout ends on its 24th rising serial-clock edge.
- R8: A high level on `chip_sel_n` during a readout drops `ser_data_oe` in that cycle, sets `pwr_down` in the next cycle and discards the result. This holds even when the cycle also carries the 24th rising edge, in which case `conv_start` stays low.
- R9: `ser_clk_present` is sampled on every cycle outside a readout and frozen during one. A high value selects `ser_clk_in`, and a low value selects the internal clock.
- R10: In internal mode `ser_clk_out` is low when the readout begins and toggles every CLK_DIV/2 system cycles, so its first rise comes CLK_DIV/2 cycles in. `ser_clk_oe` is high for the whole readout while `chip_sel_n` is low.
- R11: In external mode, a level change on `ser_clk_in` that is present before system edge k takes effect on the outputs after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Active-low select from host |
| ser_clk_in | input | 1 | Serial clock from host |
| ser_clk_present | input | 1 | High when the host drives the serial clock |
| conv_done | input | 1 | One-cycle pulse: conversion result valid |
| conv_result | input | 24 | Conversion result from the decimator |
| conv_start | output | 1 | One-cycle pulse: begin a conversion |
| pwr_down | output | 1 | Converter power-down request |
| ser_data | output | 1 | Serial result bit |
| ser_data_oe | output | 1 | Drive enable for the serial data line |
| ser_clk_out | output | 1 | Internally generated serial clock |
| ser_clk_oe | output | 1 | Drive enable for the internal serial clock |

## Verification
The sharpest collision is a select rise that lands in the same cycle as the 24th rising serial edge. In that cycle, ending the readout would start a new conversion while the abort would send the converter to power-down. The bench uses the internal clock because its timing is fixed. It counts cycles from the start of the readout and raises the select exactly in the cycle of the final rise. The cycle-accurate reference model then requires that `conv_start` stays low, that `ser_data_oe` drops at once and that `pwr_down` is high on the next cycle.

// File: rtl/scc_pkg.sv
package scc_pkg;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_SHIFT = 2'd3
    } seq_state_t;

    // Serial clock events, one system cycle wide.
    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_evt_t;

    function automatic logic is_asleep(input seq_state_t s);
        return (s == ST_IDLE) || (s == ST_HOLD);
    endfunction

    function automatic int half_of(input int d);
        return (d < 2) ? 1 : d / 2;
    endfunction

endpackage

// File: rtl/scc_clkgen.sv
module scc_clkgen
    import scc_pkg::*;
#(
    parameter int CLK_DIV = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      int_sel,
    input  logic      ext_clk,
    output sclk_evt_t evt,
    output logic      int_clk
);
    localparam int HALF = half_of(CLK_DIV);
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [2:0]    ext_pipe;
    logic [CW-1:0] div_cnt;
    logic          wrap;
    logic          ext_rise;
    logic          ext_fall;

    // two sync stages plus one history stage
    always_ff @(posedge clk) begin
        if (rst) ext_pipe <= '0;
        else     ext_pipe <= {ext_pipe[1:0], ext_clk};
    end

    assign ext_rise = ext_pipe[1] & ~ext_pipe[2];
    assign ext_fall = ~ext_pipe[1] & ext_pipe[2];

    assign wrap = (div_cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || !int_sel) begin
            div_cnt <= '0;
            int_clk <= 1'b0;
        end else if (wrap) begin
            div_cnt <= '0;
            int_clk <= ~int_clk;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    always_comb begin
        if (int_sel) begin
            evt.rise = run & wrap & ~int_clk;
            evt.fall = run & wrap & int_clk;
        end else begin
            evt.rise = ext_rise;
            evt.fall = ext_fall;
        end
    end

endmodule

// File: rtl/scc_shifter.sv
module scc_shifter
    import scc_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              active,
    input  sclk_evt_t         evt,
    output logic              msb,
    output logic              last_rise
);
    localparam int CNTW = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] sreg;
    logic [CNTW-1:0]   rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg  <= '0;
            rises <= '0;
        end else if (load) begin
            sreg  <= load_val;
            rises <= '0;
        end else if (active) begin
            if (evt.fall) sreg  <= {sreg[WORD_W-2:0], 1'b0};
            if (evt.rise) rises <= rises + 1'b1;
        end
    end

    assign msb       = sreg[WORD_W-1];
    assign last_rise = active & evt.rise & (rises == CNTW'(WORD_W - 1));

endmodule

// File: rtl/scc_seq.sv
module scc_seq
    import scc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_n,
    input  logic       conv_done,
    input  logic       last_rise,
    input  logic       present,
    output seq_state_t state,
    output logic       load,
    output logic       int_mode,
    output logic       conv_start
);
    seq_state_t state_n;

    always_comb begin
        state_n    = state;
        conv_start = 1'b0;
        case (state)
            ST_IDLE: begin
                if (!sel_n) begin
                    state_n    = ST_CONV;
                    conv_start = 1'b1;
                end
            end
            ST_CONV: begin
                if (conv_done) state_n = sel_n ? ST_HOLD : ST_SHIFT;
            end
            ST_HOLD: begin
                if (!sel_n) state_n = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (sel_n) begin
                    state_n = ST_IDLE;
                end else if (last_rise) begin
                    state_n    = ST_CONV;
                    conv_start = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign load = (state == ST_CONV) && conv_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            int_mode <= 1'b0;
        end else begin
            state <= state_n;
            if (state != ST_SHIFT) int_mode <= ~present;
        end
    end

endmodule

// File: rtl/serial_conv_ctrl.sv
module serial_conv_ctrl
    import scc_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int CLK_DIV = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_sel_n,
    input  logic              ser_clk_in,
    input  logic              ser_clk_present,
    input  logic              conv_done,
    input  logic [WORD_W-1:0] conv_result,
    output logic              conv_start,
    output logic              pwr_down,
    output logic              ser_data,
    output logic              ser_data_oe,
    output logic              ser_clk_out,
    output logic              ser_clk_oe
);
    seq_state_t state;
    sclk_evt_t  evt;
    logic       load;
    logic       int_mode;
    logic       last_rise;
    logic       shifting;

    assign shifting = (state == ST_SHIFT);

    scc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .sel_n      (chip_sel_n),
        .conv_done  (conv_done),
        .last_rise  (last_rise),
        .present    (ser_clk_present),
        .state      (state),
        .load       (load),
        .int_mode   (int_mode),
        .conv_start (conv_start)
    );

    scc_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .run     (shifting),
        .int_sel (int_mode),
        .ext_clk (ser_clk_in),
        .evt     (evt),
        .int_clk (ser_clk_out)
    );

    scc_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_val  (conv_result),
        .active    (shifting),
        .evt       (evt),
        .msb       (ser_data),
        .last_rise (last_rise)
    );

    assign pwr_down    = is_asleep(state);
    assign ser_data_oe = shifting & ~chip_sel_n;
    assign ser_clk_oe  = ser_data_oe & int_mode;

endmodule

// File: rtl/scc_chk.sv
module scc_chk (
    input logic clk,
    input logic rst,
    input logic chip_sel_n,
    input logic conv_start,
    input logic pwr_down,
    input logic ser_data,
    input logic ser_data_oe,
    input logic ser_clk_out,
    input logic ser_clk_oe
);
    // R1
    oe_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        ser_data_oe |-> !chip_sel_n);

    // R3
    asleep_silent_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> !ser_data_oe);

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R4
    start_wakes_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !pwr_down);

    // R10
    clk_en_inside_chk: assert property (@(posedge clk) disable iff (rst)
        ser_clk_oe |-> ser_data_oe);

    // R6
    data_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_clk_oe && $past(ser_clk_oe) && !$fell(ser_clk_out)) |-> $stable(ser_data));

    // R8
    abort_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_data_oe && !conv_start) ##1 chip_sel_n |=> pwr_down);

endmodule

bind serial_conv_ctrl scc_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .chip_sel_n  (chip_sel_n),
    .conv_start  (conv_start),
    .pwr_down    (pwr_down),
    .ser_data    (ser_data),
    .ser_data_oe (ser_data_oe),
    .ser_clk_out (ser_clk_out),
    .ser_clk_oe  (ser_clk_oe)
);

// File: tb/sim_serial_conv_ctrl.sv
module sim_serial_conv_ctrl;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int W      = 24;
    localparam int DIV    = 8;
    localparam int H      = DIV / 2;
    localparam int LAT    = 20;
    localparam int EXT_H  = 3;
    localparam int LAST_T = (H - 1) + 2 * H * (W - 1);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         sclk_in = 1'b0;
    logic         present = 1'b0;
    logic         done = 1'b0;
    logic [W-1:0] result = '0;
    logic         start, pd, sdata, soe, sclk_out, sclk_oe;

    int total = 0;
    int bad   = 0;
    int n_start = 0;
    int cd = 0;
    int ridx = 0;
    int ext_cnt = 0;
    bit ext_en = 0;
    bit finished = 0;

    // reference model state
    int       m_st = 0;   // 0 idle, 1 converting, 2 holding, 3 reading out
    logic [W-1:0] m_w = '0;
    int       m_r = 0;
    int       m_t = 0;
    bit       m_int = 0;
    bit       eq[$] = '{0, 0, 0};
    bit       rz, fl;
    int       nx;

    always #2.5 clk = ~clk;

    serial_conv_ctrl #(.WORD_W(W), .CLK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .chip_sel_n(cs_n), .ser_clk_in(sclk_in),
        .ser_clk_present(present), .conv_done(done), .conv_result(result),
        .conv_start(start), .pwr_down(pd), .ser_data(sdata),
        .ser_data_oe(soe), .ser_clk_out(sclk_out), .ser_clk_oe(sclk_oe)
    );

    function automatic bit m_rise();
        if (m_st != 3) return 0;
        if (m_int) return (m_t % (2 * H)) == (H - 1);
        return eq[1] && !eq[2];
    endfunction

    function automatic bit m_fall();
        if (m_st != 3) return 0;
        if (m_int) return (m_t % (2 * H)) == (2 * H - 1);
        return !eq[1] && eq[2];
    endfunction

    function automatic logic [W-1:0] gen_res(input int i);
        case (i)
            0: return 24'hFFFFFF;
            1: return 24'h800001;
            2: return 24'h00FF00;
            3: return 24'h000000;
            default: return 24'h5A3C96 ^ W'(i * 24'h13579B);
        endcase
    endfunction

    task automatic chk(input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b at %0t", what, act, exp, $time);
        end
    endtask

    // model advance at each edge
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_r = 0; m_t = 0; m_int = 0;
            eq = '{0, 0, 0};
        end else begin
            rz = m_rise();
            fl = m_fall();
            nx = m_st;
            if (m_st != 3) m_int = !present;
            case (m_st)
                0: if (!cs_n) nx = 1;
                1: if (done) begin
                       m_w = result; m_r = 0; m_t = 0;
                       nx = cs_n ? 2 : 3;
                   end
                2: if (!cs_n) begin nx = 3; m_r = 0; m_t = 0; end
                default: begin
                    if (cs_n) nx = 0;
                    else begin
                        if (fl) m_w = {m_w[W-2:0], 1'b0};
                        if (rz) begin
                            m_r++;
                            if (m_r == W) nx = 1;
                        end
                        m_t++;
                    end
                end
            endcase
            m_st = nx;
            eq.push_front(sclk_in);
            void'(eq.pop_back());
        end
    end

    // compare away from the edge, then drive the decimator stub and host clock
    always @(negedge clk) begin
        #1;
        if (!finished) begin
            chk(pd, (m_st == 0 || m_st == 2), "R3 R4 R5 R8 pwr_down");
            chk(soe, (m_st == 3 && !cs_n), "R1 R8 R9 data_oe");
            chk(start, ((m_st == 0 && !cs_n) ||
                        (m_st == 3 && !cs_n && m_rise() && m_r == W - 1)), "R2 R4 R7 conv_start");
            chk(sclk_oe, (m_st == 3 && !cs_n && m_int), "R1 R9 R10 clk_oe");
            if (m_st == 3 && !cs_n) chk(sdata, m_w[W-1], "R5 R6 R7 R11 ser_data");
            if (m_st == 3 && !cs_n && m_int) chk(sclk_out, ((m_t / H) % 2) == 1, "R10 clk_out");
        end
        if (start === 1'b1) n_start++;
        done = 1'b0;
        if (start === 1'b1) cd = LAT;
        else if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                done = 1'b1;
                result = gen_res(ridx);
                ridx++;
            end
        end
        if (ext_en) begin
            ext_cnt++;
            if (ext_cnt == EXT_H) begin
                ext_cnt = 0;
                sclk_in = ~sclk_in;
            end
        end else begin
            sclk_in = 1'b0;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R3: reset state
        chk(pd, 1'b1, "R3 reset pwr_down");
        chk(soe, 1'b0, "R3 reset data_oe");
        rst = 1'b0;
        // internal clock, continuous conversions
        repeat (3) @(negedge clk);
        cs_n = 1'b0;
        wait (n_start >= 4);
        @(negedge clk);
        cs_n = 1'b1;                     // conversion finishes into hold
        repeat (60) @(negedge clk);
        cs_n = 1'b0;                     // R5: read held result
        wait (m_st == 3 && m_t == LAST_T - 1);
        @(negedge clk);
        @(negedge clk);
        cs_n = 1'b1;                     // R8: select rise on the final rising edge
        repeat (30) @(negedge clk);
        // external clock
        present = 1'b1;
        ext_en  = 1'b1;
        repeat (20) @(negedge clk);
        cs_n = 1'b0;
        wait (n_start >= 7);
        wait (m_st == 3 && m_t >= 40);
        @(negedge clk);
        cs_n = 1'b1;                     // R8: abort mid readout
        repeat (15) @(negedge clk);
        cs_n = 1'b0;
        wait (n_start >= 9);
        @(negedge clk);
        cs_n = 1'b1;
        repeat (60) @(negedge clk);
        // R2: count of conversions started
        total++;
        if (n_start != 9) begin
            bad++;
            $display("FAIL R2 conversions act=%0d exp=%0d", n_start, 9);
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule